// File: doc/BRIEF.md
# BCH Error Location Bit Corrector

This block sits after a BCH-8 decoder that has already found the error locations for one 512-byte data sector. The decoder reports an error count and a set of 13-bit bit locations. The locations are packed tightly across three 32-bit words and one extra byte, so some locations straddle word boundaries. The block unpacks these locations and applies each fix to a byte-wide sector buffer.

Each packed location is XORed with 3 before use. The result gives a byte address (bits [11:3]) and a bit number (bits [2:0]). A location of 4096 or above points into the parity bytes, so the block skips it and toggles nothing. For each remaining location the block reads the buffer byte, flips the addressed bit and writes the byte back. It handles one location at a time. When the work ends, the block raises a one-cycle done strobe and holds the number of toggles made.

The sequencer has four states: IDLE, FETCH, PATCH and FINISH. Its transitions are:
- IDLE→FETCH: an accepted start with a count from 1 to 8.
- IDLE→FINISH: an accepted start with a count of 0 or above 8.
- FETCH→PATCH: the current location is in range, and a read is issued.
- FETCH→FETCH: the current location is out of range and is not the last one.
- FETCH→FINISH: the current location is out of range and is the last one.
- PATCH→FETCH: the write is made and more locations remain.
- PATCH→FINISH: the write is made and this was the last location.
- FINISH→IDLE: always, after one cycle.

Top module: `bch_bitfix`

## Requirements
- R1: After reset, `busy`, `done`, `uncorrectable`, `mem_rd_en` and `mem_wr_en` are 0, and `fix_cnt` is 0. While `busy` is low, no buffer access is made.
- R2: A `start` sampled high in IDLE captures `err_cnt` and the four location inputs. `busy` is 1 from the next cycle through the cycle in which `done` is high.
- R3: A count of 0 makes no buffer access. `done` is high in the first cycle after the start, with `fix_cnt` = 0 and `uncorrectable` = 0.
- R4: A count of 9 to 15 makes no buffer access and sets `uncorrectable` = 1. `done` is high in the first cycle after the start, with `fix_cnt` = 0.
- R5: The raw locations are unpacked as follows:
  - L0 = word0[12:0]
  - L1 = word0[25:13]
  - L2 = {word1[6:0], word0[31:26]}
  - L3 = word1[19:7]
  - L4 = {word2[0], word1[31:20]}
  - L5 = word2[13:1]
  - L6 = word2[26:14]
  - L7 = {byte3[7:0], word2[31:27]}
- R6: The corrected location used for a toggle is the raw location XOR 3.
- R7: A corrected location C toggles bit C[2:0] of the buffer byte at address C[11:3]. No other bit of the sector changes.
- R8: A corrected location of 4096 or above makes no buffer access, changes no data and takes one cycle.
- R9: Only locations L0 to L(N-1) are applied, in ascending order, where N is the count.
- R10: Each toggle is a read cycle (`mem_rd_en`), then a write cycle (`mem_wr_en`) to the same address. The written data is the byte returned by the read, with exactly one bit inverted. A location repeated in the list is toggled twice, which leaves the byte unchanged.
- R11: `done` is a single-cycle pulse. Counting from the cycle after the start, it occurs after 2 cycles per applied toggle plus 1 cycle per skipped location. `fix_cnt` then equals the number of toggles made and holds until the next accepted start.
- R12: A `start` while `busy` is high is ignored. The run in progress and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a correction run (accepted only when idle) |
| err_cnt | input | 4 | Number of reported error locations |
| loc_word0 | input | 32 | Packed location word 0 |
| loc_word1 | input | 32 | Packed location word 1 |
| loc_word2 | input | 32 | Packed location word 2 |
| loc_byte3 | input | 8 | Upper bits of location 7 |
| mem_rd_data | input | 8 | Buffer read data, valid one cycle after `mem_rd_en` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| fix_cnt | output | 4 | Number of bits toggled in the last run |
| uncorrectable | output | 1 | Last accepted count exceeded 8 |
| mem_addr | output | 9 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wr_data | output | 8 | Buffer write data |

## Verification
Two situations are hard to reach from the ports.

The first is a location whose meaningful bits sit on both sides of a word boundary, such as L2, L4 and L7. It is only visible when the chosen value has ones in both fragments. The stimulus table therefore stores plain 13-bit locations, and the bench packs them into the three words and the byte itself. Some vectors set bit 12 of L4, which carries only word2[0], so that location must be skipped.

The second is a start that arrives while a run is underway. The bench raises a second start with different count and words during the first FETCH cycles of a long run. It then checks that the latency, toggle count and final buffer match those of the first command alone.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
    localparam int LOC_MAX    = 8;
    localparam int IDX_W      = 13;
    localparam int SECT_BYTES = 512;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 4;
    localparam int DATA_BITS  = SECT_BYTES * BYTE_W;
    localparam int ADDR_W     = $clog2(SECT_BYTES);
    localparam int PTR_W      = $clog2(LOC_MAX);
    localparam int BITSEL_W   = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_FLIP = IDX_W'(3);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PATCH,
        ST_FINISH
    } fix_state_e;
endpackage

// File: rtl/bchfix_unpack.sv
module bchfix_unpack
    import bchfix_pkg::*;
(
    input  logic [WORD_W-1:0]                word_a,
    input  logic [WORD_W-1:0]                word_b,
    input  logic [WORD_W-1:0]                word_c,
    input  logic [BYTE_W-1:0]                byte_d,
    output logic [LOC_MAX-1:0][IDX_W-1:0]    loc_idx
);
    logic [LOC_MAX-1:0][IDX_W-1:0] raw;

    // Fixed field layout of the decoder report (R5)
    always_comb begin
        raw[0] = word_a[12:0];
        raw[1] = word_a[25:13];
        raw[2] = {word_b[6:0], word_a[31:26]};
        raw[3] = word_b[19:7];
        raw[4] = {word_c[0], word_b[31:20]};
        raw[5] = word_c[13:1];
        raw[6] = word_c[26:14];
        raw[7] = {byte_d, word_c[31:27]};
    end

    // Location adjustment applied to every slot (R6)
    for (genvar g = 0; g < LOC_MAX; g++) begin : g_flip
        assign loc_idx[g] = raw[g] ^ IDX_FLIP;
    end
endmodule

// File: rtl/bchfix_decode.sv
module bchfix_decode
    import bchfix_pkg::*;
(
    input  logic [LOC_MAX-1:0][IDX_W-1:0]   loc_idx,
    output logic [LOC_MAX-1:0][ADDR_W-1:0]  loc_addr,
    output logic [LOC_MAX-1:0][BYTE_W-1:0]  loc_mask,
    output logic [LOC_MAX-1:0]              loc_valid
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DATA_BITS);

    for (genvar g = 0; g < LOC_MAX; g++) begin : g_loc
        logic [BITSEL_W-1:0] bit_sel;
        assign bit_sel      = loc_idx[g][BITSEL_W-1:0];
        assign loc_valid[g] = (loc_idx[g] < LIMIT);
        assign loc_addr[g]  = loc_idx[g][ADDR_W+BITSEL_W-1:BITSEL_W];
        assign loc_mask[g]  = BYTE_W'(1) << bit_sel;
    end
endmodule

// File: rtl/bchfix_fsm.sv
module bchfix_fsm
    import bchfix_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [CNT_W-1:0]                err_cnt,
    input  logic [LOC_MAX-1:0][ADDR_W-1:0]  loc_addr,
    input  logic [LOC_MAX-1:0][BYTE_W-1:0]  loc_mask,
    input  logic [LOC_MAX-1:0]              loc_valid,
    input  logic [BYTE_W-1:0]               mem_rd_data,
    output logic                            load,
    output logic                            busy,
    output logic                            done,
    output logic [CNT_W-1:0]                fix_cnt,
    output logic                            uncorrectable,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic                            mem_rd_en,
    output logic                            mem_wr_en,
    output logic [BYTE_W-1:0]               mem_wr_data
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(LOC_MAX);

    fix_state_e        state_q, state_d;
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  fix_q;
    logic              uncorr_q;

    logic              cnt_zero, cnt_over, at_last, sel_valid;
    logic [ADDR_W-1:0] sel_addr;
    logic [BYTE_W-1:0] sel_mask;

    assign cnt_zero  = (err_cnt == '0);
    assign cnt_over  = (err_cnt > CNT_LIMIT);
    assign at_last   = ((CNT_W'(ptr_q) + CNT_W'(1)) == cnt_q);
    assign sel_valid = loc_valid[ptr_q];
    assign sel_addr  = loc_addr[ptr_q];
    assign sel_mask  = loc_mask[ptr_q];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (cnt_zero || cnt_over) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (sel_valid) begin
                    state_d = ST_PATCH;
                end else if (at_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_PATCH: begin
                state_d = at_last ? ST_FINISH : ST_FETCH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Run bookkeeping: pointer, latched count, toggle tally, verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            cnt_q    <= '0;
            fix_q    <= '0;
            uncorr_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q    <= '0;
                        cnt_q    <= err_cnt;
                        fix_q    <= '0;
                        uncorr_q <= cnt_over;
                    end
                end
                ST_FETCH: begin
                    if (!sel_valid && !at_last) begin
                        ptr_q <= ptr_q + PTR_W'(1);
                    end
                end
                ST_PATCH: begin
                    fix_q <= fix_q + CNT_W'(1);
                    if (!at_last) begin
                        ptr_q <= ptr_q + PTR_W'(1);
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        load        = 1'b0;
        busy        = 1'b1;
        done        = 1'b0;
        mem_addr    = '0;
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_wr_data = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_FETCH: begin
                mem_addr  = sel_addr;
                mem_rd_en = sel_valid;
            end
            ST_PATCH: begin
                mem_addr    = sel_addr;
                mem_wr_en   = 1'b1;
                mem_wr_data = mem_rd_data ^ sel_mask;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign fix_cnt       = fix_q;
    assign uncorrectable = uncorr_q;

    // ---------------- assertions ----------------
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    p_zero_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && err_cnt == '0) |=> (done && fix_cnt == '0));

    p_uncorr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |-> (!mem_rd_en && !mem_wr_en));

    p_rmw_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));

    p_rmw_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr == $past(mem_addr)));

    p_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wr_data ^ mem_rd_data) == 1));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fix_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fix_cnt <= CNT_LIMIT);

    p_ignore_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cnt_q) && busy == !$past(done)));
endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix
    import bchfix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     err_cnt,
    input  logic [WORD_W-1:0]    loc_word0,
    input  logic [WORD_W-1:0]    loc_word1,
    input  logic [WORD_W-1:0]    loc_word2,
    input  logic [BYTE_W-1:0]    loc_byte3,
    input  logic [BYTE_W-1:0]    mem_rd_data,
    output logic                 busy,
    output logic                 done,
    output logic [CNT_W-1:0]     fix_cnt,
    output logic                 uncorrectable,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_rd_en,
    output logic                 mem_wr_en,
    output logic [BYTE_W-1:0]    mem_wr_data
);
    logic                           load;
    logic [WORD_W-1:0]              w0_q, w1_q, w2_q;
    logic [BYTE_W-1:0]              b3_q;
    logic [LOC_MAX-1:0][IDX_W-1:0]  loc_idx;
    logic [LOC_MAX-1:0][ADDR_W-1:0] loc_addr;
    logic [LOC_MAX-1:0][BYTE_W-1:0] loc_mask;
    logic [LOC_MAX-1:0]             loc_valid;

    // Raw report capture, only on an accepted start (R2, R12)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w0_q <= '0;
            w1_q <= '0;
            w2_q <= '0;
            b3_q <= '0;
        end else if (load) begin
            w0_q <= loc_word0;
            w1_q <= loc_word1;
            w2_q <= loc_word2;
            b3_q <= loc_byte3;
        end
    end

    bchfix_unpack u_unpack (
        .word_a  (w0_q),
        .word_b  (w1_q),
        .word_c  (w2_q),
        .byte_d  (b3_q),
        .loc_idx (loc_idx)
    );

    bchfix_decode u_decode (
        .loc_idx   (loc_idx),
        .loc_addr  (loc_addr),
        .loc_mask  (loc_mask),
        .loc_valid (loc_valid)
    );

    bchfix_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .err_cnt       (err_cnt),
        .loc_addr      (loc_addr),
        .loc_mask      (loc_mask),
        .loc_valid     (loc_valid),
        .mem_rd_data   (mem_rd_data),
        .load          (load),
        .busy          (busy),
        .done          (done),
        .fix_cnt       (fix_cnt),
        .uncorrectable (uncorrectable),
        .mem_addr      (mem_addr),
        .mem_rd_en     (mem_rd_en),
        .mem_wr_en     (mem_wr_en),
        .mem_wr_data   (mem_wr_data)
    );

    p_start_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && w0_q == $past(loc_word0) && b3_q == $past(loc_byte3)));
endmodule

// File: tb/sim_bch_bitfix.sv
`timescale 1ns/1ps
module sim_bch_bitfix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  err_cnt = '0;
    logic [31:0] loc_word0 = '0, loc_word1 = '0, loc_word2 = '0;
    logic [7:0]  loc_byte3 = '0;
    logic [7:0]  mem_rd_data;
    logic        busy, done, uncorrectable, mem_rd_en, mem_wr_en;
    logic [3:0]  fix_cnt;
    logic [8:0]  mem_addr;
    logic [7:0]  mem_wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] bufm   [512];
    logic [7:0] golden [512];

    always #10 clk = ~clk;

    bch_bitfix u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .err_cnt(err_cnt),
        .loc_word0(loc_word0), .loc_word1(loc_word1), .loc_word2(loc_word2),
        .loc_byte3(loc_byte3), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .fix_cnt(fix_cnt), .uncorrectable(uncorrectable),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data)
    );

    // Sector buffer model: one-cycle read latency, filled during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 512; a++) bufm[a] <= 8'(a) ^ 8'h5A;
            mem_rd_data <= '0;
        end else begin
            if (mem_wr_en) bufm[mem_addr] <= mem_wr_data;
            if (mem_rd_en) mem_rd_data <= bufm[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // {count, L0, L1, ... L7}: raw 13-bit locations before the bench packs them
    localparam int NV = 10;
    localparam logic [107:0] VEC [NV] = '{
        {4'd1,  13'h0003, 13'h0111, 13'h0222, 13'h0333, 13'h0444, 13'h0555, 13'h0666, 13'h0777},
        {4'd8,  13'h0010, 13'h0123, 13'h0FFF, 13'h0456, 13'h0789, 13'h0ABC, 13'h0DEF, 13'h0F00},
        {4'd3,  13'h0055, 13'h1000, 13'h1FFF, 13'h0001, 13'h0002, 13'h0003, 13'h0004, 13'h0005},
        {4'd2,  13'h0200, 13'h0200, 13'h0300, 13'h0301, 13'h0302, 13'h0303, 13'h0304, 13'h0305},
        {4'd4,  13'h0A01, 13'h0B02, 13'h0C03, 13'h0D04, 13'h0E05, 13'h0F06, 13'h0107, 13'h0208},
        {4'd0,  13'h0400, 13'h0401, 13'h0402, 13'h0403, 13'h0404, 13'h0405, 13'h0406, 13'h0407},
        {4'd9,  13'h0500, 13'h0501, 13'h0502, 13'h0503, 13'h0504, 13'h0505, 13'h0506, 13'h0507},
        {4'd15, 13'h0600, 13'h0601, 13'h0602, 13'h0603, 13'h0604, 13'h0605, 13'h0606, 13'h0607},
        {4'd8,  13'h0FC0, 13'h003F, 13'h0FFE, 13'h0555, 13'h1001, 13'h0AAA, 13'h0E1E, 13'h0FFE},
        {4'd7,  13'h0FFC, 13'h1003, 13'h0000, 13'h0007, 13'h0ABE, 13'h07F8, 13'h0C0C, 13'h0123}
    };

    task automatic run_vec(input logic [107:0] v, input bit poke, input string name);
        logic [12:0] ix [8];
        logic [3:0]  cnt;
        logic [12:0] c;
        int nv, ns, n, bad;
        cnt = v[107:104];
        for (int k = 0; k < 8; k++) ix[k] = v[103-13*k -: 13];
        nv = 0; ns = 0;
        if (cnt >= 1 && cnt <= 8) begin
            for (int k = 0; k < int'(cnt); k++) begin
                c = ix[k] ^ 13'd3;
                if (c < 13'd4096) begin
                    golden[c[11:3]] = golden[c[11:3]] ^ (8'd1 << c[2:0]);
                    nv++;
                end else begin
                    ns++;
                end
            end
        end
        @(negedge clk);
        err_cnt   = cnt;
        loc_word0 = {ix[2][5:0], ix[1], ix[0]};
        loc_word1 = {ix[4][11:0], ix[3], ix[2][12:6]};
        loc_word2 = {ix[7][4:0], ix[6], ix[5], ix[4][12]};
        loc_byte3 = ix[7][12:5];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check(busy == 1'b1 || done == 1'b1, {"R2 busy after start ", name}, int'(busy), 1);
        if (poke) begin
            err_cnt = 4'd0; loc_word0 = '1; loc_word1 = '1; loc_word2 = '1; loc_byte3 = '1;
            start = 1'b1;
            @(negedge clk); n++;
            @(negedge clk); n++;
            start = 1'b0;
        end
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(n == 1 + 2*nv + ns, {"R11 latency ", name}, n, 1 + 2*nv + ns);
        check(busy == 1'b1, {"R2 busy with done ", name}, int'(busy), 1);
        check(fix_cnt == 4'(nv), {"R9 R11 toggle count ", name}, int'(fix_cnt), nv);
        check(uncorrectable == (cnt > 4'd8), {"R4 verdict ", name}, int'(uncorrectable), int'(cnt > 4'd8));
        @(negedge clk);
        check(!done && !busy, {"R11 done single pulse ", name}, int'(done), 0);
        check(fix_cnt == 4'(nv), {"R11 count held ", name}, int'(fix_cnt), nv);
        bad = 0;
        for (int a = 0; a < 512; a++) if (bufm[a] !== golden[a]) bad++;
        check(bad == 0, {"R5 R6 R7 R8 R10 buffer contents ", name}, bad, 0);
    endtask

    initial begin
        for (int a = 0; a < 512; a++) golden[a] = 8'(a) ^ 8'h5A;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !uncorrectable, "R1 reset flags", int'(busy) + int'(done), 0);
        check(!mem_rd_en && !mem_wr_en, "R1 no access in reset", int'(mem_rd_en), 0);
        check(fix_cnt == 4'd0, "R1 reset count", int'(fix_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_rd_en && !mem_wr_en, "R1 idle after reset", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], 1'b0, $sformatf("vec%0d", i));
        end
        // R3: count 0 right after a real run leaves count cleared
        run_vec({4'd0, 13'h0100, 13'h0101, 13'h0102, 13'h0103, 13'h0104, 13'h0105, 13'h0106, 13'h0107},
                1'b0, "R3 zero");
        // R12: second start during a long run must be ignored
        run_vec({4'd6, 13'h0011, 13'h0822, 13'h0433, 13'h0C44, 13'h0255, 13'h0A66, 13'h0000, 13'h0000},
                1'b1, "R12 poke");
        // R4: uncorrectable following a good run
        run_vec({4'd12, 13'h0011, 13'h0822, 13'h0433, 13'h0C44, 13'h0255, 13'h0A66, 13'h0000, 13'h0000},
                1'b0, "R4 twelve");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule